// File: doc/BRIEF.md
# Dual-Port Memory with Per-Port Output Preset

This block is a synchronous two-port memory. Ports A and B each have an enable, a write enable, an address, write data and a registered read output. Both ports share one clock. A port does nothing on a clock edge where its enable is low. On an edge where its enable is high, the port can write the addressed word, and its output register takes either the word stored at the address before that edge or a fixed preset value.

The preset is loaded by a per-port set/reset input. Each port has its own preset constant, fixed at elaboration, as wide as the full data word. A parameter sets whether the set/reset input is active high (the default) or active low. The preset acts only on the output register and only on an edge where that port is enabled. It never changes a stored word and never interferes with the other port's access.

Use the block where a consumer needs a known output value (for example a neutral word) after a burst of reads, without spending a write to change the memory.

Top module: `dpram_sr_top`

## Requirements
- R1: While a port's enable is low, its data output keeps its previous value on every edge, whatever that port's write enable, set/reset, address and data inputs do. It does not return to zero.
- R2: On an enabled edge with set/reset inactive, the port's output shows the stored word at the port's address, one clock after that edge.
- R3: A read and a write on the same port on the same edge is read-first: the output shows the word as it was before the write.
- R4: On an enabled edge with set/reset active, the port's output becomes that port's own preset value (PRESET_A or PRESET_B). This takes priority over the read data.
- R5: A set/reset asserted while the port's enable is low is ignored, and the output keeps its value.
- R6: A set/reset never changes any stored word. A write requested on the same port on the same edge as a set/reset still updates the memory.
- R7: A set/reset on one port does not disturb a write or a read made by the other port on the same edge.
- R8: A write happens only when the port's enable and write enable are both high. A write attempted with enable low leaves the memory unchanged.
- R9: When SR_ACTIVE_HIGH is 0, a low level on the set/reset input loads the preset, and a high level lets read data through.
- R10: The two ports work independently. A word written through one port can be read through the other. A port reading the address the other port writes on the same edge sees the old word. Two writes to the same address on the same edge leave that word undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_sr | input | 1 | Port A output set/reset (polarity set by SR_ACTIVE_HIGH) |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A registered read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_sr | input | 1 | Port B output set/reset (polarity set by SR_ACTIVE_HIGH) |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | DATA_W | Port B write data |
| b_dout | output | DATA_W | Port B registered read data |

## Verification
Every address is first loaded with a distinct word, so a read from the wrong address or an output stuck at zero shows a mismatch. The vector table then drives several patterns:
- both ports writing different addresses, then reading back crosswise, which tells the two write paths apart;
- an idle edge with write enable and set/reset raised, which separates gated from ungated control;
- a same-port write with a read, which distinguishes read-first from write-first;
- a set/reset combined with a write, followed later by reading that address, which separates an output-only preset from one that corrupts or blocks the array.

A second instance with the active-low setting checks that the polarity inverts.

// File: rtl/dpram_sr_pkg.sv
package dpram_sr_pkg;

  typedef enum logic [1:0] {
    OUT_HOLD  = 2'd0,
    OUT_READ  = 2'd1,
    OUT_PRESET = 2'd2
  } out_sel_e;

  // Level on the pin translated to "set/reset requested"
  function automatic logic sr_asserted(input logic pin, input bit active_high);
    return active_high ? pin : !pin;
  endfunction

  // Choice for the output register on one edge: idle holds, preset wins over read
  function automatic out_sel_e out_select(input logic en, input logic sr_on);
    if (!en)   return OUT_HOLD;
    if (sr_on) return OUT_PRESET;
    return OUT_READ;
  endfunction

endpackage

// File: rtl/dpram_sr_array.sv
module dpram_sr_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              wa_fire,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_fire,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // One process owns the array; a same-address double write is undefined by contract
  always_ff @(posedge clk) begin
    if (wa_fire) cells[wa_addr] <= wa_data;
    if (wb_fire) cells[wb_addr] <= wb_data;
  end

  // Pre-edge contents feed the output registers, giving read-first behaviour
  assign ra_data = cells[ra_addr];
  assign rb_data = cells[rb_addr];

endmodule

// File: rtl/dpram_sr_port_ctl.sv
module dpram_sr_port_ctl
  import dpram_sr_pkg::*;
#(
  parameter bit SR_ACTIVE_HIGH = 1'b1
) (
  input  logic     en,
  input  logic     we,
  input  logic     sr_pin,
  output logic     wr_fire,
  output logic     sr_fire,
  output logic     rd_fire,
  output out_sel_e sel
);
  logic sr_on;

  assign sr_on   = sr_asserted(sr_pin, SR_ACTIVE_HIGH);
  assign sel     = out_select(en, sr_on);
  // Write path is independent of the preset: the array still updates
  assign wr_fire = en & we;
  assign sr_fire = (sel == OUT_PRESET);
  assign rd_fire = (sel == OUT_READ);

endmodule

// File: rtl/dpram_sr_outreg.sv
module dpram_sr_outreg
  import dpram_sr_pkg::*;
#(
  parameter int                DATA_W  = 36,
  parameter logic [DATA_W-1:0] PRESET  = '0
) (
  input  logic              clk,
  input  out_sel_e          sel,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    unique case (sel)
      OUT_PRESET: dout <= PRESET;
      OUT_READ:   dout <= rdata;
      default:    dout <= dout;
    endcase
  end

endmodule

// File: rtl/dpram_sr_top.sv
module dpram_sr_top
  import dpram_sr_pkg::*;
#(
  parameter int                ADDR_W         = 6,
  parameter int                DATA_W         = 36,
  parameter logic [DATA_W-1:0] PRESET_A       = '0,
  parameter logic [DATA_W-1:0] PRESET_B       = '0,
  parameter bit                SR_ACTIVE_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic              a_sr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  input  logic              b_en,
  input  logic              b_we,
  input  logic              b_sr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout
);
  localparam int NPORT = 2;

  // Per-port views, index 0 = A, 1 = B
  logic [NPORT-1:0]  en_v, we_v, sr_v;
  logic [ADDR_W-1:0] addr_v  [NPORT];
  logic [DATA_W-1:0] din_v   [NPORT];
  logic [DATA_W-1:0] rdata_v [NPORT];
  logic [DATA_W-1:0] dout_v  [NPORT];

  // Internal events, named for the checker
  logic [NPORT-1:0]  wr_fire, sr_fire, rd_fire;
  out_sel_e          sel_v [NPORT];

  assign en_v      = {b_en, a_en};
  assign we_v      = {b_we, a_we};
  assign sr_v      = {b_sr, a_sr};
  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;
  assign din_v[0]  = a_din;
  assign din_v[1]  = b_din;

  dpram_sr_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) array_i (
    .clk     (clk),
    .wa_fire (wr_fire[0]),
    .wa_addr (addr_v[0]),
    .wa_data (din_v[0]),
    .wb_fire (wr_fire[1]),
    .wb_addr (addr_v[1]),
    .wb_data (din_v[1]),
    .ra_addr (addr_v[0]),
    .ra_data (rdata_v[0]),
    .rb_addr (addr_v[1]),
    .rb_data (rdata_v[1])
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [DATA_W-1:0] PORT_PRESET = (p == 0) ? PRESET_A : PRESET_B;

    dpram_sr_port_ctl #(
      .SR_ACTIVE_HIGH (SR_ACTIVE_HIGH)
    ) ctl_i (
      .en      (en_v[p]),
      .we      (we_v[p]),
      .sr_pin  (sr_v[p]),
      .wr_fire (wr_fire[p]),
      .sr_fire (sr_fire[p]),
      .rd_fire (rd_fire[p]),
      .sel     (sel_v[p])
    );

    dpram_sr_outreg #(
      .DATA_W (DATA_W),
      .PRESET (PORT_PRESET)
    ) out_i (
      .clk   (clk),
      .sel   (sel_v[p]),
      .rdata (rdata_v[p]),
      .dout  (dout_v[p])
    );
  end

  assign a_dout = dout_v[0];
  assign b_dout = dout_v[1];

endmodule

// File: rtl/dpram_sr_chk.sv
module dpram_sr_chk #(
  parameter int                ADDR_W         = 6,
  parameter int                DATA_W         = 36,
  parameter logic [DATA_W-1:0] PRESET_A       = '0,
  parameter logic [DATA_W-1:0] PRESET_B       = '0,
  parameter bit                SR_ACTIVE_HIGH = 1'b1
) (
  input logic              clk,
  input logic              a_en,
  input logic              a_sr,
  input logic [DATA_W-1:0] a_rdata,
  input logic [DATA_W-1:0] a_dout,
  input logic              b_en,
  input logic              b_sr,
  input logic [DATA_W-1:0] b_rdata,
  input logic [DATA_W-1:0] b_dout
);
  logic warm = 1'b0;
  always_ff @(posedge clk) warm <= 1'b1;

  logic a_sr_on, b_sr_on;
  assign a_sr_on = SR_ACTIVE_HIGH ? a_sr : !a_sr;
  assign b_sr_on = SR_ACTIVE_HIGH ? b_sr : !b_sr;

  // R1
  a_idle_hold_chk: assert property (@(posedge clk) disable iff (!warm)
    !a_en |=> $stable(a_dout));
  // R1
  b_idle_hold_chk: assert property (@(posedge clk) disable iff (!warm)
    !b_en |=> $stable(b_dout));
  // R4
  a_preset_load_chk: assert property (@(posedge clk) disable iff (!warm)
    (a_en && a_sr_on) |=> (a_dout == PRESET_A));
  // R4
  b_preset_load_chk: assert property (@(posedge clk) disable iff (!warm)
    (b_en && b_sr_on) |=> (b_dout == PRESET_B));
  // R2
  a_read_path_chk: assert property (@(posedge clk) disable iff (!warm)
    (a_en && !a_sr_on) |=> (a_dout == $past(a_rdata)));
  // R2
  b_read_path_chk: assert property (@(posedge clk) disable iff (!warm)
    (b_en && !b_sr_on) |=> (b_dout == $past(b_rdata)));

endmodule

bind dpram_sr_top dpram_sr_chk #(
  .ADDR_W         (ADDR_W),
  .DATA_W         (DATA_W),
  .PRESET_A       (PRESET_A),
  .PRESET_B       (PRESET_B),
  .SR_ACTIVE_HIGH (SR_ACTIVE_HIGH)
) chk_i (
  .clk     (clk),
  .a_en    (a_en),
  .a_sr    (a_sr),
  .a_rdata (rdata_v[0]),
  .a_dout  (a_dout),
  .b_en    (b_en),
  .b_sr    (b_sr),
  .b_rdata (rdata_v[1]),
  .b_dout  (b_dout)
);

// File: tb/dpram_sr_top_tb_top.sv
module dpram_sr_top_tb_top;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int NWORDS = 1 << AW;
  localparam logic [DW-1:0] PRE_A  = 36'h0A5A5A5A5;
  localparam logic [DW-1:0] PRE_B  = 36'hF0F0F00FF;
  localparam logic [DW-1:0] PRE_LO = 36'h123456789;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic          a_en = 0, a_we = 0, a_sr = 0, b_en = 0, b_we = 0, b_sr = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_din = '0, b_din = '0;
  logic [DW-1:0] a_dout, b_dout;

  dpram_sr_top #(
    .ADDR_W(AW), .DATA_W(DW), .PRESET_A(PRE_A), .PRESET_B(PRE_B), .SR_ACTIVE_HIGH(1'b1)
  ) dut_i (
    .clk(clk),
    .a_en(a_en), .a_we(a_we), .a_sr(a_sr), .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout),
    .b_en(b_en), .b_we(b_we), .b_sr(b_sr), .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout)
  );

  // Active-low instance for the polarity requirement
  logic          lo_en = 0, lo_we = 0, lo_sr = 1;
  logic [AW-1:0] lo_addr = '0;
  logic [DW-1:0] lo_din = '0;
  logic [DW-1:0] lo_dout, lo_bdout;

  dpram_sr_top #(
    .ADDR_W(AW), .DATA_W(DW), .PRESET_A(PRE_LO), .PRESET_B(PRE_B), .SR_ACTIVE_HIGH(1'b0)
  ) dut_lo (
    .clk(clk),
    .a_en(lo_en), .a_we(lo_we), .a_sr(lo_sr), .a_addr(lo_addr), .a_din(lo_din), .a_dout(lo_dout),
    .b_en(1'b0), .b_we(1'b0), .b_sr(1'b1), .b_addr('0), .b_din('0), .b_dout(lo_bdout)
  );

  // Behavioural model
  logic [DW-1:0] mdl [NWORDS];
  logic [DW-1:0] exp_a, exp_b;

  typedef struct packed {
    logic ea, wa, sa; logic [AW-1:0] aa; logic [DW-1:0] da;
    logic eb, wb, sb; logic [AW-1:0] ab; logic [DW-1:0] db;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    // R8 R10: both ports write distinct addresses
    '{1,1,0, 6'd3, 36'h111, 1,1,0, 6'd5, 36'h222, 4'd10},
    // R2 R10: crosswise read-back
    '{1,0,0, 6'd5, 36'h0,   1,0,0, 6'd3, 36'h0,   4'd2},
    // R1 R5: idle with we and sr raised
    '{0,1,1, 6'd5, 36'hBAD, 0,1,1, 6'd3, 36'hBAD, 4'd1},
    // R8: B attempts write with enable low
    '{1,0,0, 6'd3, 36'h0,   0,1,0, 6'd3, 36'h999, 4'd8},
    // R3 R10: A write-with-read, B reads same address
    '{1,1,0, 6'd3, 36'h333, 1,0,0, 6'd3, 36'h0,   4'd3},
    // R4: A preset over read
    '{1,0,1, 6'd3, 36'h0,   1,0,0, 6'd3, 36'h0,   4'd4},
    // R6: A preset plus write, B writes elsewhere
    '{1,1,1, 6'd7, 36'h777, 1,1,0, 6'd9, 36'h909, 4'd6},
    // R6 R4: A reads written word, B preset
    '{1,0,0, 6'd7, 36'h0,   1,0,1, 6'd7, 36'h0,   4'd6},
    // R7: B preset while A writes
    '{1,1,0, 6'd12,36'hC12, 1,0,1, 6'd12,36'h0,   4'd7},
    // R7: read back
    '{1,0,0, 6'd12,36'h0,   1,0,0, 6'd9, 36'h0,   4'd7},
    // R5: preset with enable low
    '{0,0,1, 6'd0, 36'h0,   0,0,1, 6'd0, 36'h0,   4'd5},
    // R6: array untouched by earlier presets
    '{1,0,0, 6'd9, 36'h0,   1,0,0, 6'd7, 36'h0,   4'd6},
    // R4: both presets together
    '{1,0,1, 6'd1, 36'h0,   1,0,1, 6'd2, 36'h0,   4'd4},
    // R2: boundary addresses
    '{1,0,0, 6'd0, 36'h0,   1,0,0, 6'd63,36'h0,   4'd2}
  };

  task automatic check(input string what, input int req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic step(input vec_t v, input bit do_chk);
    logic [DW-1:0] na, nb;
    a_en = v.ea; a_we = v.wa; a_sr = v.sa; a_addr = v.aa; a_din = v.da;
    b_en = v.eb; b_we = v.wb; b_sr = v.sb; b_addr = v.ab; b_din = v.db;
    @(posedge clk);
    na = v.ea ? (v.sa ? PRE_A : mdl[v.aa]) : exp_a;
    nb = v.eb ? (v.sb ? PRE_B : mdl[v.ab]) : exp_b;
    if (v.ea && v.wa) mdl[v.aa] = v.da;
    if (v.eb && v.wb) mdl[v.ab] = v.db;
    exp_a = na; exp_b = nb;
    @(negedge clk);
    if (do_chk) begin
      check("port A", int'(v.req), a_dout, exp_a);
      check("port B", int'(v.req), b_dout, exp_b);
    end
  endtask

  initial begin
    vec_t pv;
    exp_a = '0; exp_b = '0;
    @(negedge clk);
    // Preload every word with a distinct value through port A
    for (int i = 0; i < NWORDS; i++) begin
      pv = '0;
      pv.ea = 1; pv.wa = 1; pv.aa = AW'(i);
      pv.da = 36'h500000000 + DW'(i) * 36'h10001 + 36'h77;
      step(pv, 1'b0);
    end
    // Vector table
    for (int k = 0; k < NVEC; k++) step(VECS[k], 1'b1);

    // Directed: active-low polarity (R9)
    a_en = 0; b_en = 0;
    lo_en = 1; lo_we = 1; lo_sr = 1; lo_addr = 6'd1; lo_din = 36'h0ABCDEF01;
    @(negedge clk);
    lo_we = 0; lo_sr = 0;          // low level = preset
    @(negedge clk);
    check("active-low preset", 9, lo_dout, PRE_LO);
    lo_sr = 1;                     // high level = pass read data
    @(negedge clk);
    check("active-low read", 9, lo_dout, 36'h0ABCDEF01);
    lo_en = 0; lo_sr = 0;          // R5: preset ignored while disabled
    @(negedge clk);
    @(negedge clk);
    check("active-low disabled preset", 5, lo_dout, 36'h0ABCDEF01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule